// File: doc/BRIEF.md
# Watchpoint and Breakpoint Event Combiner

This block sits between the debug comparators of a processor pipeline and the exception logic. Each instruction that enters the tracked window brings two sets of raw comparator hits. One set comes from the instruction-address comparators. The other comes from the load/store comparators. A programmable AND-OR matrix turns the instruction hits into four instruction watchpoints and one instruction breakpoint. A second matrix combines two of those watchpoints with the load/store hits to form two load/store watchpoints and one load/store breakpoint.

The formed events wait in an in-order queue until the pipeline retires or squashes the instruction. Only retired instructions report anything. At retirement the breakpoints pass through the masked or non-masked gate and the per-breakpoint trap enables. A debug host loads those enables bit by bit over a serial write path while the core runs. A taken load/store breakpoint captures the access address.

The issue side is a valid/ready stream. `iss_ready` falls only when the queue already holds `DEPTH` unretired instructions. An issue is accepted on a clock edge where `iss_valid` and `iss_ready` are both high. If the queue is full, the producer holds the beat. Retirement, flush and all event outputs are plain pulses with no handshake, so the block never stalls retirement.

Top module: `wbc_combiner`

## Requirements
- R1: Every matrix output has two product terms, each with its own AND mask. A term fires when its mask is nonzero and every input selected by the mask is 1. The output is the OR of its two terms, and a term whose mask is all zero never fires. The mask for output o, term t sits at bits [(o*2+t)*W +: W], where W is the matrix input width.
- R2: The instruction matrix has W=4 and takes `ic_match` as its input vector. Its outputs 0 to 3 are instruction watchpoints 0 to 3, and its output 4 is the instruction breakpoint.
- R3: The load/store matrix has W=6. Its input vector puts instruction watchpoint 0 at bit 0, instruction watchpoint 1 at bit 1 and `ls_match[3:0]` at bits 5:2. Its outputs 0 and 1 are load/store watchpoints 0 and 1, and its output 2 is the load/store breakpoint.
- R4: `wp_pin` = {load/store watchpoint 1, load/store watchpoint 0, instruction watchpoint 2, instruction watchpoint 1, instruction watchpoint 0}.
- R5: Events are reported only at retirement. After a clock edge with `ret_valid` high, a non-empty queue and `flush` low, `evt_valid` is 1 for one cycle and the outputs carry the oldest pending instruction's events, in issue order. In every other cycle all event outputs are 0.
- R6: `flush` discards every pending instruction, including one issued in the same cycle. `flush` takes priority over a `ret_valid` in the same cycle.
- R7: When `masked_mode` is 1, a breakpoint is taken only while `bk_gen` is 1. When `masked_mode` is 0, `bk_gen` is ignored. Both inputs are sampled at retirement.
- R8: Serial trap-enable load. Each cycle with `dbg_shift` high shifts `dbg_sdi` into a 2-bit register: the first bit shifted becomes the load/store enable and the second becomes the instruction enable. A `dbg_commit` pulse copies that register into the live enables. Shifting alone changes nothing, and both enables are 0 after reset. A breakpoint is taken only if its enable is set.
- R9: A taken instruction breakpoint blocks the access. For that instruction, `lbp_take` and `wp_lwp` stay 0 and `bar` is not updated. The instruction watchpoints are still reported.
- R10: A taken load/store breakpoint loads the instruction's `ls_addr` into `bar`. `bar` holds its value at all other times and is 0 after reset.
- R11: `iss_ready` is 0 exactly when `DEPTH` instructions are pending. An issue presented while `iss_ready` is 0 is dropped. A retirement with no pending instruction produces no event.
- R12: After reset, `iss_ready` is 1 and all event outputs and `bar` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Instruction enters the tracked window |
| iss_ready | output | 1 | Queue can accept an instruction |
| ic_match | input | 4 | Instruction comparator hits |
| ls_match | input | 4 | Load/store comparator hits |
| ls_addr | input | AW | Address of the instruction's access |
| ret_valid | input | 1 | Oldest pending instruction retires |
| flush | input | 1 | Squash all pending instructions |
| cfg_imask | input | 40 | Instruction matrix term masks |
| cfg_lmask | input | 36 | Load/store matrix term masks |
| masked_mode | input | 1 | Breakpoints gated by the global enable |
| bk_gen | input | 1 | Global breakpoint enable |
| dbg_shift | input | 1 | Shift one trap-enable bit |
| dbg_sdi | input | 1 | Serial trap-enable data |
| dbg_commit | input | 1 | Apply the shifted trap enables |
| evt_valid | output | 1 | A retirement was reported |
| wp_iwp | output | 4 | Retired instruction watchpoints |
| wp_lwp | output | 2 | Retired load/store watchpoints |
| wp_pin | output | 5 | Watchpoint pins |
| ibp_take | output | 1 | Instruction breakpoint taken |
| lbp_take | output | 1 | Load/store breakpoint taken |
| bar | output | AW | Captured breakpoint access address |

## Verification
The hardest case to reach is one retiring instruction that raises an instruction breakpoint, a load/store breakpoint and a load/store watchpoint together. This needs both matrices programmed so one instruction hits all three. It also needs both trap enables loaded through the serial path and `bar` already holding an earlier address, so that a wrong capture is visible. The stimulus first takes a load/store breakpoint to set `bar`. It then issues the triple-hit instruction and checks that only the instruction breakpoint and the instruction watchpoints appear. Flush colliding with a same-cycle retire or issue, and an issue refused while the queue is full, are driven as separate directed scenarios.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  localparam int N_ICMP  = 4;
  localparam int N_IWP   = 4;
  localparam int N_LCMP  = 4;
  localparam int N_LWP   = 2;
  localparam int N_LQUAL = 2;
  localparam int N_TERM  = 2;
  localparam int N_IPIN  = 3;
  localparam int N_BP    = 2;
  localparam int N_IOUT  = N_IWP + 1;
  localparam int N_LIN   = N_LQUAL + N_LCMP;
  localparam int N_LOUT  = N_LWP + 1;

  typedef struct packed {
    logic [N_IWP-1:0] iwp;
    logic             ibp;
    logic [N_LWP-1:0] lwp;
    logic             lbp;
  } wbc_evt_t;
endpackage

// File: rtl/wbc_andor.sv
module wbc_andor #(
  parameter int NIN   = 4,
  parameter int NOUT  = 5,
  parameter int NTERM = 2
) (
  input  logic [NIN-1:0]            vec_i,
  input  logic [NOUT*NTERM*NIN-1:0] mask_i,
  output logic [NOUT-1:0]           hit_o
);
  for (genvar o = 0; o < NOUT; o++) begin : g_out
    logic [NTERM-1:0] term;
    for (genvar t = 0; t < NTERM; t++) begin : g_term
      logic [NIN-1:0] m;
      assign m       = mask_i[(o*NTERM+t)*NIN +: NIN];
      // an empty product term is disabled rather than always true
      assign term[t] = (|m) && ((vec_i & m) == m);
    end
    assign hit_o[o] = |term;
  end
endmodule

// File: rtl/wbc_evq.sv
module wbc_evq #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  input  logic         clr,
  output logic         full,
  output logic         empty,
  output logic [W-1:0] dout
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;
  assign dout    = mem[rd_q];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= (wr_q == PW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_q <= (rd_q == PW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/wbc_trapld.sv
module wbc_trapld #(
  parameter int NBP = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_i,
  input  logic           sdi_i,
  input  logic           commit_i,
  output logic [NBP-1:0] en_o
);
  logic [NBP-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q <= '0;
      en_o <= '0;
    end else begin
      if (shift_i)  sr_q <= {sr_q[NBP-2:0], sdi_i};
      if (commit_i) en_o <= sr_q;
    end
  end
endmodule

// File: rtl/wbc_combiner.sv
module wbc_combiner
  import wbc_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            iss_valid,
  output logic                            iss_ready,
  input  logic [N_ICMP-1:0]               ic_match,
  input  logic [N_LCMP-1:0]               ls_match,
  input  logic [AW-1:0]                   ls_addr,
  input  logic                            ret_valid,
  input  logic                            flush,
  input  logic [N_IOUT*N_TERM*N_ICMP-1:0] cfg_imask,
  input  logic [N_LOUT*N_TERM*N_LIN-1:0]  cfg_lmask,
  input  logic                            masked_mode,
  input  logic                            bk_gen,
  input  logic                            dbg_shift,
  input  logic                            dbg_sdi,
  input  logic                            dbg_commit,
  output logic                            evt_valid,
  output logic [N_IWP-1:0]                wp_iwp,
  output logic [N_LWP-1:0]                wp_lwp,
  output logic [N_IPIN+N_LWP-1:0]         wp_pin,
  output logic                            ibp_take,
  output logic                            lbp_take,
  output logic [AW-1:0]                   bar
);
  localparam int EW = $bits(wbc_evt_t);
  localparam int QW = AW + EW;

  logic [N_IOUT-1:0] i_hit;
  logic [N_LIN-1:0]  l_vec;
  logic [N_LOUT-1:0] l_hit;
  wbc_evt_t          evt_in, head;
  logic [AW-1:0]     head_addr;
  logic [QW-1:0]     q_dout;
  logic              q_full, q_empty;
  logic [N_BP-1:0]   trap_en;
  logic              retire_now, gate, ibp_t, lbp_t;
  logic [N_LWP-1:0]  lwp_eff;

  wbc_andor #(.NIN(N_ICMP), .NOUT(N_IOUT), .NTERM(N_TERM)) u_imat (
    .vec_i(ic_match), .mask_i(cfg_imask), .hit_o(i_hit)
  );

  assign l_vec = {ls_match, i_hit[N_LQUAL-1:0]};

  wbc_andor #(.NIN(N_LIN), .NOUT(N_LOUT), .NTERM(N_TERM)) u_lmat (
    .vec_i(l_vec), .mask_i(cfg_lmask), .hit_o(l_hit)
  );

  always_comb begin
    evt_in.iwp = i_hit[N_IWP-1:0];
    evt_in.ibp = i_hit[N_IWP];
    evt_in.lwp = l_hit[N_LWP-1:0];
    evt_in.lbp = l_hit[N_LWP];
  end

  wbc_evq #(.W(QW), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n),
    .push(iss_valid), .din({ls_addr, evt_in}),
    .pop(ret_valid), .clr(flush),
    .full(q_full), .empty(q_empty), .dout(q_dout)
  );

  assign iss_ready = !q_full;
  assign head      = wbc_evt_t'(q_dout[EW-1:0]);
  assign head_addr = q_dout[QW-1:EW];

  wbc_trapld #(.NBP(N_BP)) u_trap (
    .clk(clk), .rst_n(rst_n),
    .shift_i(dbg_shift), .sdi_i(dbg_sdi), .commit_i(dbg_commit),
    .en_o(trap_en)
  );

  // trap_en[1] load/store breakpoint, trap_en[0] instruction breakpoint
  assign retire_now = ret_valid && !q_empty && !flush;
  assign gate       = !masked_mode || bk_gen;
  assign ibp_t      = head.ibp && trap_en[0] && gate;
  assign lbp_t      = head.lbp && trap_en[1] && gate && !ibp_t;
  assign lwp_eff    = ibp_t ? '0 : head.lwp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_valid <= 1'b0;
      wp_iwp    <= '0;
      wp_lwp    <= '0;
      wp_pin    <= '0;
      ibp_take  <= 1'b0;
      lbp_take  <= 1'b0;
      bar       <= '0;
    end else begin
      evt_valid <= retire_now;
      wp_iwp    <= retire_now ? head.iwp : '0;
      wp_lwp    <= retire_now ? lwp_eff : '0;
      wp_pin    <= retire_now ? {lwp_eff, head.iwp[N_IPIN-1:0]} : '0;
      ibp_take  <= retire_now && ibp_t;
      lbp_take  <= retire_now && lbp_t;
      if (retire_now && lbp_t) bar <= head_addr;
    end
  end
endmodule

// File: rtl/wbc_combiner_chk.sv
module wbc_combiner_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ret_valid,
  input logic          flush,
  input logic          masked_mode,
  input logic          bk_gen,
  input logic          evt_valid,
  input logic          ibp_take,
  input logic          lbp_take,
  input logic [1:0]    wp_lwp,
  input logic [AW-1:0] bar
);
  a_r5_only_on_retire: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> $past(ret_valid && !flush));

  a_r5_quiet_bp: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |-> (!ibp_take && !lbp_take && wp_lwp == 2'b00));

  a_r6_flush_drops: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !evt_valid);

  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (ibp_take || lbp_take) |-> $past(!masked_mode || bk_gen));

  a_r9_ibp_first: assert property (@(posedge clk) disable iff (!rst_n)
    ibp_take |-> (!lbp_take && wp_lwp == 2'b00));

  a_r10_bar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lbp_take |-> $stable(bar));
endmodule

bind wbc_combiner wbc_combiner_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .flush(flush),
  .masked_mode(masked_mode), .bk_gen(bk_gen), .evt_valid(evt_valid),
  .ibp_take(ibp_take), .lbp_take(lbp_take), .wp_lwp(wp_lwp), .bar(bar)
);

// File: tb/wbc_combiner_bench.sv
module wbc_combiner_bench;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0, ret_valid = 1'b0, flush = 1'b0;
  logic [3:0] ic_match = '0, ls_match = '0;
  logic [AW-1:0] ls_addr = '0;
  logic [39:0] cfg_imask = '0;
  logic [35:0] cfg_lmask = '0;
  logic masked_mode = 1'b0, bk_gen = 1'b0;
  logic dbg_shift = 1'b0, dbg_sdi = 1'b0, dbg_commit = 1'b0;
  logic iss_ready, evt_valid, ibp_take, lbp_take;
  logic [3:0] wp_iwp;
  logic [1:0] wp_lwp;
  logic [4:0] wp_pin;
  logic [AW-1:0] bar;
  int n_vec = 0, n_bad = 0;

  always #10 clk = ~clk;

  wbc_combiner #(.DEPTH(4), .AW(AW)) u_wbc_combiner (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .ic_match(ic_match), .ls_match(ls_match), .ls_addr(ls_addr),
    .ret_valid(ret_valid), .flush(flush), .cfg_imask(cfg_imask),
    .cfg_lmask(cfg_lmask), .masked_mode(masked_mode), .bk_gen(bk_gen),
    .dbg_shift(dbg_shift), .dbg_sdi(dbg_sdi), .dbg_commit(dbg_commit),
    .evt_valid(evt_valid), .wp_iwp(wp_iwp), .wp_lwp(wp_lwp), .wp_pin(wp_pin),
    .ibp_take(ibp_take), .lbp_take(lbp_take), .bar(bar)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] ic, input logic [3:0] ls, input logic [AW-1:0] a);
    @(negedge clk);
    iss_valid = 1'b1; ic_match = ic; ls_match = ls; ls_addr = a;
    @(negedge clk);
    iss_valid = 1'b0; ic_match = '0; ls_match = '0;
  endtask

  task automatic retire();
    @(negedge clk); ret_valid = 1'b1;
    @(negedge clk); ret_valid = 1'b0;
  endtask

  task automatic load_trap(input logic lbp_en, input logic ibp_en);
    @(negedge clk); dbg_shift = 1'b1; dbg_sdi = lbp_en;
    @(negedge clk); dbg_sdi = ibp_en;
    @(negedge clk); dbg_shift = 1'b0; dbg_commit = 1'b1;
    @(negedge clk); dbg_commit = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 iss_ready", iss_ready, 1);
    chk("R12 evt_valid", evt_valid, 0);
    chk("R12 wp_pin", wp_pin, 0);
    chk("R12 bar", bar, 0);
  endtask

  task automatic t_inst_matrix();
    cfg_imask[0 +: 4]  = 4'b0011;               // out0 term0
    cfg_imask[8 +: 4]  = 4'b0100;               // out1 term0
    cfg_imask[12 +: 4] = 4'b1000;               // out1 term1
    cfg_imask[24 +: 4] = 4'b1111;               // out3 term0, out2 empty
    issue(4'b0011, 4'b0000, 0); retire();
    chk("R1 R2 and-term iwp", wp_iwp, 4'b0001);
    chk("R4 pin", wp_pin, 5'b00001);
    issue(4'b1000, 4'b0000, 0); retire();
    chk("R1 second term iwp", wp_iwp, 4'b0010);
    issue(4'b1111, 4'b0000, 0); retire();
    chk("R1 empty mask never fires", wp_iwp, 4'b1011);
    chk("R4 pin all", wp_pin, 5'b00011);
    chk("R2 no ibp", ibp_take, 0);
  endtask

  task automatic t_ls_matrix();
    cfg_lmask[0 +: 6]  = 6'b000001;             // lwp0 from iwp0
    cfg_lmask[12 +: 6] = 6'b110000;             // lwp1 from ls_match[3:2]
    issue(4'b0011, 4'b1100, 0); retire();
    chk("R3 lwp", wp_lwp, 2'b11);
    chk("R4 pin ls", wp_pin, 5'b11001);
    issue(4'b0000, 4'b0100, 0); retire();
    chk("R3 partial lwp", wp_lwp, 2'b00);
  endtask

  task automatic t_retire_order();
    issue(4'b0011, 0, 0); issue(4'b1000, 0, 0); issue(4'b1111, 0, 0);
    chk("R5 silent before retire", evt_valid, 0);
    retire(); chk("R5 order 1", wp_iwp, 4'b0001);
    retire(); chk("R5 order 2", wp_iwp, 4'b0010);
    retire(); chk("R5 order 3", wp_iwp, 4'b1011);
    @(negedge clk);
    chk("R5 one-cycle pulse", evt_valid, 0);
    retire(); chk("R11 empty retire", evt_valid, 0);
  endtask

  task automatic t_flush();
    issue(4'b0011, 0, 0); issue(4'b1000, 0, 0);
    @(negedge clk); flush = 1'b1; ret_valid = 1'b1;
    @(negedge clk); flush = 1'b0; ret_valid = 1'b0;
    chk("R6 flush beats retire", evt_valid, 0);
    retire(); chk("R6 pending dropped", evt_valid, 0);
    @(negedge clk); iss_valid = 1'b1; flush = 1'b1; ic_match = 4'b0011;
    @(negedge clk); iss_valid = 1'b0; flush = 1'b0; ic_match = '0;
    retire(); chk("R6 same-cycle issue dropped", evt_valid, 0);
  endtask

  task automatic t_trap_serial();
    cfg_imask[32 +: 4] = 4'b0001;               // ibp term0
    issue(4'b0001, 0, 0); retire();
    chk("R8 reset enables off", ibp_take, 0);
    chk("R8 still reported", evt_valid, 1);
    @(negedge clk); dbg_shift = 1'b1; dbg_sdi = 1'b0;
    @(negedge clk); dbg_sdi = 1'b1;
    @(negedge clk); dbg_shift = 1'b0;
    issue(4'b0001, 0, 0); retire();
    chk("R8 shift without commit", ibp_take, 0);
    @(negedge clk); dbg_commit = 1'b1;
    @(negedge clk); dbg_commit = 1'b0;
    issue(4'b0001, 0, 0); retire();
    chk("R8 committed ibp enable", ibp_take, 1);
  endtask

  task automatic t_masked();
    masked_mode = 1'b1; bk_gen = 1'b0;
    issue(4'b0001, 0, 0); retire();
    chk("R7 masked blocked", ibp_take, 0);
    bk_gen = 1'b1;
    issue(4'b0001, 0, 0); retire();
    chk("R7 masked enabled", ibp_take, 1);
    masked_mode = 1'b0; bk_gen = 1'b0;
    issue(4'b0001, 0, 0); retire();
    chk("R7 non-masked ignores enable", ibp_take, 1);
  endtask

  task automatic t_lbp_bar();
    load_trap(1'b1, 1'b1);
    cfg_lmask[24 +: 6] = 6'b000100;             // lbp from ls_match[0]
    issue(4'b0000, 4'b0001, 32'hA5); retire();
    chk("R10 lbp taken", lbp_take, 1);
    chk("R10 bar captured", bar, 32'hA5);
    issue(4'b0000, 4'b0000, 32'h3C); retire();
    chk("R10 bar holds", bar, 32'hA5);
  endtask

  task automatic t_ibp_priority();
    issue(4'b0001, 4'b1101, 32'h77); retire();
    chk("R9 ibp taken", ibp_take, 1);
    chk("R9 lbp suppressed", lbp_take, 0);
    chk("R9 lwp suppressed", wp_lwp, 0);
    chk("R9 bar untouched", bar, 32'hA5);
  endtask

  task automatic t_backpressure();
    issue(4'b0011, 0, 0); issue(4'b1000, 0, 0);
    issue(4'b0011, 0, 0); issue(4'b1000, 0, 0);
    chk("R11 full", iss_ready, 0);
    issue(4'b1111, 0, 0);
    retire(); chk("R11 entry 1", wp_iwp, 4'b0001);
    chk("R11 ready again", iss_ready, 1);
    retire(); chk("R11 entry 2", wp_iwp, 4'b0010);
    retire(); chk("R11 entry 3", wp_iwp, 4'b0001);
    retire(); chk("R11 entry 4", wp_iwp, 4'b0010);
    retire(); chk("R11 refused issue absent", evt_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_inst_matrix();
    t_ls_matrix();
    t_retire_order();
    t_flush();
    t_trap_serial();
    t_masked();
    t_lbp_bar();
    t_ibp_priority();
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule